// File: doc/BRIEF.md
# Multi-Bank Edge-Triggered Interrupt Controller

This block collects external event lines, grouped in banks of 32, and turns selected signal edges into latched interrupt requests. Every line passes through a two-flop synchroniser. Each line then has its own choice of edge sensitivity: rising, falling, or both. A rising edge is recorded in one pending register and a falling edge in a second, separate one. Software clears a pending bit by writing a 1 to it. Software can also inject an event on a line through a self-clearing software event register.

For each bank, a per-line mask combines the pending bits of that bank into one level-high interrupt output. Some lines are built as direct lines: they never latch a pending bit, and their synchronised level goes straight out, gated by the mask. A line can be withdrawn from use in either of two ways. One is a per-bank security register. The other is a per-line owner register: the line is withdrawn when filtering is enabled and the owner ID is any value other than 1. All registers sit on a simple single-cycle write and combinational read port.

Top module: `edge_irq_ctl`

## Requirements
- R1: Line n belongs to bank n/32 and uses bit n%32 of that bank's registers. The per-bank registers of bank b sit at 0x20*b plus: rising select 0x00, falling select 0x04, software event 0x08, rising pending 0x0C, falling pending 0x10, security 0x14. The mask register is at 0x80 + 0x10*b.
- R2: A line detects rising edges only when its rising-select bit is 1, and falling edges only when its falling-select bit is 1. Setting both bits makes it sensitive to both edges.
- R3: A rising input edge sets the line's rising-pending bit. The bit is readable 3 clock edges after the input change and not before.
- R4: A falling input edge on a line with falling select set sets its falling-pending bit, with the same 3-edge latency. It leaves the rising-pending bit untouched.
- R5: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A clear and a new event in the same cycle leave the bit set.
- R6: Writing 1 to a bit of the software event register sets that line's rising-pending bit on the same clock edge, whatever the select bits hold. The software event register always reads 0.
- R7: Output irq_o[b] is high exactly while some line of bank b has a pending bit set, its mask bit set, and is not reserved.
- R8: A line whose bank security bit is 1 is reserved. Reserved lines latch no pending bit from edges or software events, and they drive neither irq_o nor direct_o.
- R9: The owner register of line n is at 0x180 + 4n, with bit 0 the filter enable and bits 6:4 the owner ID. It reads back what was written. The line is reserved when the enable is 1 and the ID is not 1.
- R10: The read-only register at 0x3F0 returns the owner-ID width in bits 27:24 and the bank count in bits 3:0. With the defaults it reads 0x03000003.
- R11: The read-only trigger-type register of bank b is at 0x3EC - 4*b, where a 1 bit marks a configurable line. A direct line (0 bit) never sets a pending bit, and drives direct_o with its synchronised level ANDed with its mask bit, 2 clock edges after the input change.
- R12: After reset every writable register, every pending bit, irq_o and direct_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_BANKS*32 | Asynchronous event lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_o | output | NUM_BANKS | Level-high interrupt, one per bank |
| direct_o | output | NUM_BANKS*32 | Masked level of each direct line |

## Verification
An input change made between clock edges is synchronised by the first two edges. It is seen as an edge by combinational logic after the second edge and is latched into pending at the third. The bench therefore reads pending one edge early to confirm the bit is still clear, and again exactly after the third edge. Direct outputs follow the second flop and are sampled after two edges. Software events, write-1 clears and mask changes take effect on the write's own edge, and reads are combinational, so every read happens half a period after the edge of interest. The same-cycle clear-versus-set case is timed by placing the clear write on the third edge of a line transition.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
   localparam int unsigned REG_W        = 32;
   localparam int unsigned ADDR_W       = 12;
   localparam int unsigned BANK_STRIDE  = 32'h20;
   localparam int unsigned OFS_RSEL     = 32'h00;
   localparam int unsigned OFS_FSEL     = 32'h04;
   localparam int unsigned OFS_SWEV     = 32'h08;
   localparam int unsigned OFS_RPND     = 32'h0C;
   localparam int unsigned OFS_FPND     = 32'h10;
   localparam int unsigned OFS_SEC      = 32'h14;
   localparam int unsigned MASK_BASE    = 32'h80;
   localparam int unsigned MASK_STRIDE  = 32'h10;
   localparam int unsigned OWN_BASE     = 32'h180;
   localparam int unsigned TRIG_TOP     = 32'h3EC;
   localparam int unsigned HWCFG_ADDR   = 32'h3F0;

   function automatic logic [ADDR_W-1:0] bank_reg(input int unsigned b, input int unsigned ofs);
      return ADDR_W'(BANK_STRIDE * b + ofs);
   endfunction

   function automatic logic [ADDR_W-1:0] mask_reg(input int unsigned b);
      return ADDR_W'(MASK_BASE + MASK_STRIDE * b);
   endfunction

   function automatic logic [ADDR_W-1:0] trig_reg(input int unsigned b);
      return ADDR_W'(TRIG_TOP - 4 * b);
   endfunction
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] level_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   logic [N-1:0] meta_q, stab_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         stab_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= async_i;
         stab_q <= meta_q;
         prev_q <= stab_q;
      end
   end

   assign level_o = stab_q;
   assign rise_o  = stab_q & ~prev_q;
   assign fall_o  = ~stab_q & prev_q;
endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank
   import edge_irq_pkg::*;
#(
   parameter int unsigned BANK  = 0,
   parameter int unsigned LINES = 32,
   parameter logic [LINES-1:0] CFG = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  rise_i,
   input  logic [LINES-1:0]  fall_i,
   input  logic [LINES-1:0]  level_i,
   input  logic [LINES-1:0]  owner_res_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata_o,
   output logic              irq_o,
   output logic [LINES-1:0]  direct_o,
   output logic [LINES-1:0]  rsel_o,
   output logic [LINES-1:0]  fsel_o,
   output logic [LINES-1:0]  rpend_o,
   output logic [LINES-1:0]  fpend_o,
   output logic [LINES-1:0]  res_o
);
   localparam logic [ADDR_W-1:0] A_RSEL = bank_reg(BANK, OFS_RSEL);
   localparam logic [ADDR_W-1:0] A_FSEL = bank_reg(BANK, OFS_FSEL);
   localparam logic [ADDR_W-1:0] A_SWEV = bank_reg(BANK, OFS_SWEV);
   localparam logic [ADDR_W-1:0] A_RPND = bank_reg(BANK, OFS_RPND);
   localparam logic [ADDR_W-1:0] A_FPND = bank_reg(BANK, OFS_FPND);
   localparam logic [ADDR_W-1:0] A_SEC  = bank_reg(BANK, OFS_SEC);
   localparam logic [ADDR_W-1:0] A_MASK = mask_reg(BANK);
   localparam logic [ADDR_W-1:0] A_TRIG = trig_reg(BANK);

   logic [LINES-1:0] rsel_q, fsel_q, rpnd_q, fpnd_q, sec_q, mask_q;
   logic [LINES-1:0] wd, usable, sw_ev, r_set, f_set, r_clr, f_clr;

   assign wd     = wdata[LINES-1:0];
   assign res_o  = sec_q | owner_res_i;
   assign usable = CFG & ~res_o;
   assign sw_ev  = (wr_en && addr == A_SWEV) ? wd : '0;
   assign r_set  = usable & ((rise_i & rsel_q) | sw_ev);
   assign f_set  = usable & fall_i & fsel_q;
   assign r_clr  = (wr_en && addr == A_RPND) ? wd : '0;
   assign f_clr  = (wr_en && addr == A_FPND) ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_q <= '0;
         fsel_q <= '0;
         rpnd_q <= '0;
         fpnd_q <= '0;
         sec_q  <= '0;
         mask_q <= '0;
      end else begin
         if (wr_en && addr == A_RSEL) rsel_q <= wd;
         if (wr_en && addr == A_FSEL) fsel_q <= wd;
         if (wr_en && addr == A_SEC)  sec_q  <= wd;
         if (wr_en && addr == A_MASK) mask_q <= wd;
         rpnd_q <= (rpnd_q & ~r_clr) | r_set;
         fpnd_q <= (fpnd_q & ~f_clr) | f_set;
      end
   end

   assign irq_o    = |((rpnd_q | fpnd_q) & mask_q & ~res_o);
   assign direct_o = level_i & ~CFG & mask_q & ~res_o;
   assign rsel_o   = rsel_q;
   assign fsel_o   = fsel_q;
   assign rpend_o  = rpnd_q;
   assign fpend_o  = fpnd_q;

   always_comb begin
      rdata_o = '0;
      if (addr == A_RSEL) rdata_o = REG_W'(rsel_q);
      if (addr == A_FSEL) rdata_o = REG_W'(fsel_q);
      if (addr == A_RPND) rdata_o = REG_W'(rpnd_q);
      if (addr == A_FPND) rdata_o = REG_W'(fpnd_q);
      if (addr == A_SEC)  rdata_o = REG_W'(sec_q);
      if (addr == A_MASK) rdata_o = REG_W'(mask_q);
      if (addr == A_TRIG) rdata_o = REG_W'(CFG);
   end
endmodule

// File: rtl/edge_irq_owner.sv
module edge_irq_owner
   import edge_irq_pkg::*;
#(
   parameter int unsigned LINES   = 96,
   parameter int unsigned OWNER_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en_bit,
   input  logic [2:0]        wr_id,
   output logic [REG_W-1:0]  rdata_o,
   output logic [LINES-1:0]  res_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   generate
      if (OWNER_W == 0) begin : g_none
         assign rdata_o = '0;
         assign res_o   = '0;
      end else begin : g_filter
         logic [ADDR_W-1:0]  rel;
         logic [IDX_W-1:0]   idx;
         logic               in_rng;
         logic [LINES-1:0]   en_q;
         logic [OWNER_W-1:0] id_q [LINES];

         assign rel    = addr - ADDR_W'(OWN_BASE);
         assign idx    = rel[ADDR_W-1:2];
         assign in_rng = (addr >= ADDR_W'(OWN_BASE)) && (rel[1:0] == 2'b00)
                         && (idx < IDX_W'(LINES));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q <= '0;
               for (int n = 0; n < LINES; n++) id_q[n] <= '0;
            end else if (wr_en && in_rng) begin
               for (int n = 0; n < LINES; n++) begin
                  if (idx == IDX_W'(n)) begin
                     en_q[n] <= wr_en_bit;
                     id_q[n] <= wr_id[OWNER_W-1:0];
                  end
               end
            end
         end

         always_comb begin
            rdata_o = '0;
            for (int n = 0; n < LINES; n++) begin
               if (in_rng && idx == IDX_W'(n)) begin
                  rdata_o[0]           = en_q[n];
                  rdata_o[4+:OWNER_W]  = id_q[n];
               end
            end
         end

         for (genvar n = 0; n < LINES; n++) begin : g_res
            assign res_o[n] = en_q[n] && (id_q[n] != OWNER_W'(1));
         end
      end
   endgenerate
endmodule

// File: rtl/edge_irq_ctl.sv
module edge_irq_ctl
   import edge_irq_pkg::*;
#(
   parameter int unsigned NUM_BANKS  = 3,
   parameter int unsigned BANK_LINES = 32,
   parameter int unsigned OWNER_W    = 3,
   parameter logic [NUM_BANKS*BANK_LINES-1:0] CFG_LINES =
      96'h0000FFFF_FFFFFFFF_FFFFFFFF
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_BANKS*BANK_LINES-1:0]  line_i,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [REG_W-1:0]                 wdata,
   output logic [REG_W-1:0]                 rdata,
   output logic [NUM_BANKS-1:0]             irq_o,
   output logic [NUM_BANKS*BANK_LINES-1:0]  direct_o
);
   localparam int unsigned NUM_LINES = NUM_BANKS * BANK_LINES;

   generate
      if (BANK_LINES < 1 || BANK_LINES > REG_W) begin : g_bad_lines
         $error("BANK_LINES must lie in 1..32");
      end
      if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
         $error("NUM_BANKS must lie in 1..4");
      end
      if (OWNER_W > 3) begin : g_bad_owner
         $error("OWNER_W must not exceed 3");
      end
   endgenerate

   logic [NUM_LINES-1:0] level_all, rise_all, fall_all, owner_res;
   logic [NUM_LINES-1:0] rsel_all, fsel_all, rpend_all, fpend_all, res_all;
   logic [REG_W-1:0]     bank_rd [NUM_BANKS];
   logic [REG_W-1:0]     owner_rd, hwcfg;

   edge_irq_sync #(.N(NUM_LINES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (line_i),
      .level_o (level_all),
      .rise_o  (rise_all),
      .fall_o  (fall_all)
   );

   edge_irq_owner #(.LINES(NUM_LINES), .OWNER_W(OWNER_W)) u_owner (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wr_en_bit (wdata[0]),
      .wr_id     (wdata[6:4]),
      .rdata_o   (owner_rd),
      .res_o     (owner_res)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      edge_irq_bank #(
         .BANK  (b),
         .LINES (BANK_LINES),
         .CFG   (CFG_LINES[b*BANK_LINES +: BANK_LINES])
      ) u_bank (
         .clk         (clk),
         .rst_n       (rst_n),
         .rise_i      (rise_all[b*BANK_LINES +: BANK_LINES]),
         .fall_i      (fall_all[b*BANK_LINES +: BANK_LINES]),
         .level_i     (level_all[b*BANK_LINES +: BANK_LINES]),
         .owner_res_i (owner_res[b*BANK_LINES +: BANK_LINES]),
         .wr_en       (wr_en),
         .addr        (addr),
         .wdata       (wdata),
         .rdata_o     (bank_rd[b]),
         .irq_o       (irq_o[b]),
         .direct_o    (direct_o[b*BANK_LINES +: BANK_LINES]),
         .rsel_o      (rsel_all[b*BANK_LINES +: BANK_LINES]),
         .fsel_o      (fsel_all[b*BANK_LINES +: BANK_LINES]),
         .rpend_o     (rpend_all[b*BANK_LINES +: BANK_LINES]),
         .fpend_o     (fpend_all[b*BANK_LINES +: BANK_LINES]),
         .res_o       (res_all[b*BANK_LINES +: BANK_LINES])
      );
   end

   assign hwcfg = {4'b0, 4'(OWNER_W), 20'b0, 4'(NUM_BANKS)};

   always_comb begin
      rdata = owner_rd;
      for (int b = 0; b < NUM_BANKS; b++) rdata = rdata | bank_rd[b];
      if (addr == ADDR_W'(HWCFG_ADDR)) rdata = hwcfg;
   end
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
   parameter int unsigned NL = 96,
   parameter logic [NL-1:0] CFG = '1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [NL-1:0] rise_all,
   input logic [NL-1:0] fall_all,
   input logic [NL-1:0] rsel_all,
   input logic [NL-1:0] fsel_all,
   input logic [NL-1:0] rpend_all,
   input logic [NL-1:0] fpend_all,
   input logic [NL-1:0] res_all
);
   logic [NL-1:0] due_r, due_f;
   assign due_r = rise_all & rsel_all & CFG & ~res_all;
   assign due_f = fall_all & fsel_all & CFG & ~res_all;

   // R3, R5: a qualified rising edge is latched even against a same-cycle clear
   a_r3_rise_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (|due_r) |=> ((rpend_all & $past(due_r)) == $past(due_r)));

   // R4: a qualified falling edge is latched
   a_r4_fall_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (|due_f) |=> ((fpend_all & $past(due_f)) == $past(due_f)));

   // R8: reserved lines gain no new pending bits
   a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (|res_all) |=> (((rpend_all & ~$past(rpend_all)) | (fpend_all & ~$past(fpend_all)))
                      & $past(res_all)) == '0);

   // R6: a new rising-pending bit without a hardware edge needs a register write
   a_r6_sw_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rpend_all & ~$past(rpend_all) & ~$past(rise_all))) |-> $past(wr_en));

   // R11: direct lines never hold pending state
   a_r11_direct_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rpend_all | fpend_all)) |-> (((rpend_all | fpend_all) & ~CFG) == '0));
endmodule

bind edge_irq_ctl edge_irq_chk #(.NL(NUM_LINES), .CFG(CFG_LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rise_all  (rise_all),
   .fall_all  (fall_all),
   .rsel_all  (rsel_all),
   .fsel_all  (fsel_all),
   .rpend_all (rpend_all),
   .fpend_all (fpend_all),
   .res_all   (res_all)
);

// File: tb/edge_irq_ctl_test.sv
`timescale 1ns/1ps
module edge_irq_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] lines = '0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [2:0]  irq_o;
   logic [95:0] direct_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   edge_irq_ctl uut (
      .clk(clk), .rst_n(rst_n), .line_i(lines), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .direct_o(direct_o)
   );

   function automatic logic [11:0] ra(input int b, input int ofs);
      return 12'(32 * b + ofs);
   endfunction

   function automatic logic [11:0] ma(input int b);
      return 12'(128 + 16 * b);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic check_line(input int n, input int mode);
      logic [31:0] v, bitv, er, ef;
      int b;
      b    = n / 32;
      bitv = 32'h1 << (n % 32);
      er   = mode[0] ? bitv : 32'h0;
      ef   = mode[1] ? bitv : 32'h0;
      wr(ra(b, 'h00), er);
      wr(ra(b, 'h04), ef);
      lines[n] = 1'b1;
      repeat (2) @(negedge clk);
      rd(ra(b, 'h0C), v);
      chk("R3 rising pending not yet set after 2 edges", v, 32'h0);
      @(negedge clk);
      rd(ra(b, 'h0C), v);
      chk("R1 R2 R3 rising pending after 3 edges", v, er);
      chk("R7 irq after rising", 32'(irq_o), (er != 0) ? (32'h1 << b) : 32'h0);
      lines[n] = 1'b0;
      repeat (3) @(negedge clk);
      rd(ra(b, 'h10), v);
      chk("R2 R4 falling pending", v, ef);
      rd(ra(b, 'h0C), v);
      chk("R4 rising pending untouched by fall", v, er);
      chk("R7 irq after falling", 32'(irq_o), ((er | ef) != 0) ? (32'h1 << b) : 32'h0);
      wr(ra(b, 'h0C), 32'hFFFF_FFFF);
      wr(ra(b, 'h10), 32'hFFFF_FFFF);
      rd(ra(b, 'h0C), v);
      chk("R5 rising pending cleared", v, 32'h0);
      rd(ra(b, 'h10), v);
      chk("R5 falling pending cleared", v, 32'h0);
      chk("R7 irq low after clear", 32'(irq_o), 32'h0);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      for (int b = 0; b < 3; b++) begin
         for (int o = 0; o < 24; o += 4) begin
            rd(ra(b, o), v);
            chk("R12 bank register reset", v, 32'h0);
         end
         rd(ma(b), v);
         chk("R12 mask reset", v, 32'h0);
      end
      chk("R12 irq reset", 32'(irq_o), 32'h0);
      chk("R12 direct reset", 32'(direct_o != '0), 32'h0);
      rd(12'h3F0, v);
      chk("R10 hardware config", v, 32'h0300_0003);
      rd(12'h3EC, v);
      chk("R11 trigger type bank0", v, 32'hFFFF_FFFF);
      rd(12'h3E8, v);
      chk("R11 trigger type bank1", v, 32'hFFFF_FFFF);
      rd(12'h3E4, v);
      chk("R11 trigger type bank2", v, 32'h0000_FFFF);

      for (int b = 0; b < 3; b++) wr(ma(b), 32'hFFFF_FFFF);
      rd(ma(1), v);
      chk("R1 mask readback bank1", v, 32'hFFFF_FFFF);

      // sweep every configurable line over the three edge modes
      for (int n = 0; n < 80; n++) check_line(n, (n % 3) + 1);

      // R6 software event
      wr(ra(1, 'h00), 32'h0);
      wr(ra(1, 'h08), 32'h0000_0420);
      rd(ra(1, 'h0C), v);
      chk("R6 software event sets rising pending", v, 32'h0000_0420);
      rd(ra(1, 'h08), v);
      chk("R6 software event reads zero", v, 32'h0);
      chk("R7 irq from software event", 32'(irq_o), 32'h2);
      wr(ra(1, 'h0C), 32'h0000_0020);
      rd(ra(1, 'h0C), v);
      chk("R5 partial clear", v, 32'h0000_0400);
      wr(ra(1, 'h0C), 32'h0);
      rd(ra(1, 'h0C), v);
      chk("R5 writing zero no effect", v, 32'h0000_0400);
      wr(ra(1, 'h0C), 32'hFFFF_FFFF);

      // R7 mask gating
      wr(ma(0), 32'h0);
      wr(ra(0, 'h08), 32'h80);
      chk("R7 masked line keeps irq low", 32'(irq_o), 32'h0);
      wr(ma(0), 32'h80);
      chk("R7 unmasking raises irq", 32'(irq_o), 32'h1);
      wr(ma(0), 32'hFFFF_FFFF);

      // R5 clear loses to same-cycle edge (pending bit 7 still set, add line 3)
      wr(ra(0, 'h00), 32'h8);
      wr(ra(0, 'h08), 32'h8);
      lines[3] = 1'b1;
      @(negedge clk);
      wr(ra(0, 'h0C), 32'h88);
      rd(ra(0, 'h0C), v);
      chk("R5 set wins over same-cycle clear", v, 32'h8);
      lines[3] = 1'b0;
      repeat (3) @(negedge clk);
      wr(ra(0, 'h0C), 32'hFFFF_FFFF);
      rd(ra(0, 'h0C), v);
      chk("R5 clear without event", v, 32'h0);

      // R8 security reserve
      wr(ra(0, 'h14), 32'h20);
      rd(ra(0, 'h14), v);
      chk("R8 security readback", v, 32'h20);
      wr(ra(0, 'h00), 32'h20);
      wr(ra(0, 'h08), 32'h20);
      lines[5] = 1'b1;
      repeat (3) @(negedge clk);
      rd(ra(0, 'h0C), v);
      chk("R8 reserved line latches nothing", v, 32'h0);
      chk("R8 reserved line no irq", 32'(irq_o), 32'h0);
      lines[5] = 1'b0;
      repeat (3) @(negedge clk);
      wr(ra(0, 'h14), 32'h0);

      // R9 owner filtering on line 40 (bank1 bit8)
      wr(12'h220, 32'h21);
      rd(12'h220, v);
      chk("R9 owner register readback", v, 32'h21);
      wr(ra(1, 'h08), 32'h100);
      rd(ra(1, 'h2C - 'h20), v);
      chk("R9 foreign owner reserves line", v, 32'h0);
      wr(12'h220, 32'h11);
      wr(ra(1, 'h08), 32'h100);
      rd(ra(1, 'h0C), v);
      chk("R9 owner 1 leaves line usable", v, 32'h100);
      wr(12'h220, 32'h20);
      wr(ra(1, 'h0C), 32'hFFFF_FFFF);
      wr(ra(1, 'h08), 32'h100);
      rd(ra(1, 'h0C), v);
      chk("R9 disabled filter leaves line usable", v, 32'h100);
      wr(ra(1, 'h0C), 32'hFFFF_FFFF);

      // R11 direct line 85 (bank2 bit21)
      lines[85] = 1'b1;
      @(negedge clk);
      chk("R11 direct not yet after 1 edge", 32'(direct_o[85]), 32'h0);
      @(negedge clk);
      chk("R11 direct follows level after 2 edges", 32'(direct_o[85]), 32'h1);
      wr(ra(2, 'h08), 32'h0020_0000);
      rd(ra(2, 'h0C), v);
      chk("R11 direct line holds no pending", v, 32'h0);
      chk("R11 direct line no bank irq", 32'(irq_o), 32'h0);
      wr(ma(2), 32'h0);
      chk("R11 direct masked off", 32'(direct_o[85]), 32'h0);
      lines[85] = 1'b0;

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule